// File: doc/BRIEF.md
# Passive Serial Configuration Master

This block loads a configuration image into an SRAM-based programmable device over a passive serial link. A one-cycle start pulse begins the sequence. The block pulses the active-low configuration request line and confirms that the device pulls its active-low status line low in reply. It then releases the request and waits, with a timeout, for the device to let its status line go high. After that it pulls image bytes from a valid/ready byte stream and shifts each one out on the serial data line, sampled by the device on rising edges of the serial clock.

Once the byte flagged as last has been shifted, the block samples the device's completion input. If that input is high, the block gives a fixed number of extra clock pulses so the device can finish initialising, then reports done. Each failure point stops the sequence, returns the link lines to their idle levels and latches a 2-bit error code. The code stays until the next start pulse. All delays and the serial-clock half period are parameters counted in system clock cycles.

Top module: `ps_config_master`

## Requirements
- R1: While reset is held and after reset, the request output is high, the serial clock and data outputs are low, and busy, done, error and s_ready are all low.
- R2: A start pulse in idle drives the request output low for exactly T_CFG_CYC system clock cycles and clears any previous error and done.
- R3: If the status input is still high at the end of the request-low interval, the block stops with error code 1. Busy lasts exactly T_CFG_CYC cycles.
- R4: After the request is released the block waits T_REL_CYC cycles and then waits for the status input to go high. If it is still low after T_TMO_CYC more cycles, the block stops with error code 2. Busy lasts T_CFG_CYC+T_REL_CYC+T_TMO_CYC cycles.
- R5: Each byte is sent least significant bit first, one serial clock rising edge per bit, eight per byte. The data output changes only while the serial clock is low.
- R6: Every high phase of the serial clock lasts exactly HALF_CYC system cycles. Elaboration checks that CLK_HZ/(2*HALF_CYC) does not exceed 50 MHz.
- R7: s_ready is high only when the shifter is empty and the block is waiting for a byte. While the stream stalls between bytes the serial clock stays low.
- R8: If the completion input is low after the last-flagged byte has been shifted, the block stops with error code 3 and gives no extra clock pulses.
- R9: If the completion input is high after the last byte, the block gives exactly TRAIL_PULSES (default 12) extra serial clock pulses, each high then low, and then raises done with error low.
- R10: On any error the request output returns high, the serial clock goes low and busy drops. Error and its nonzero code hold until the next start.
- R11: Stream bytes offered while the block is idle, or before the device has released its status line, are not accepted (s_ready stays low and no clock edge occurs).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a configuration |
| s_data | input | 8 | Image byte |
| s_valid | input | 1 | Image byte is valid |
| s_last | input | 1 | Marks the final image byte |
| s_ready | output | 1 | Block takes the byte this cycle |
| ncfg_o | output | 1 | Active-low configuration request to the device |
| dclk_o | output | 1 | Serial clock to the device |
| data0_o | output | 1 | Serial data to the device |
| nstatus_i | input | 1 | Active-low device status |
| confdone_i | input | 1 | Device completion flag, high when loaded |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last configuration completed |
| error | output | 1 | Last configuration failed |
| err_code | output | 2 | 1 status not low, 2 status release timeout, 3 completion low |

## Verification
The bench runs a behavioural device that reassembles bytes from rising clock edges and compares them against a computed pattern. If the bit order were wrong, or data moved while the clock was high, those bytes would mismatch. Stream stalls between bytes are used to catch a design that lets the clock run while it has no byte to send. The bench checks exact cycle counts for the request pulse, the status-release timeout and the clock high time, so a timer that is off by one cycle is reported. In the completion-low case, the bench catches a design that still gives trailing pulses or reports done.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CFG,
        S_REL,
        S_WAIT,
        S_LOAD,
        S_SHIFT,
        S_CHK,
        S_TRAIL
    } seq_state_e;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_NOSTAT = 2'd1,
        ERR_TMO    = 2'd2,
        ERR_CONF   = 2'd3
    } err_e;

    typedef struct packed {
        logic [7:0] data;
        logic       last;
    } byte_beat_t;

    localparam longint unsigned DCLK_MAX_HZ = 64'd50_000_000;

    function automatic int unsigned max4(int unsigned a, int unsigned b,
                                         int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic bit dclk_rate_ok(longint unsigned clk_hz, int unsigned half);
        return (half != 0) && (clk_hz <= DCLK_MAX_HZ * 2 * longint'(half));
    endfunction

endpackage

// File: rtl/ps_cfg_timer.sv
module ps_cfg_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/ps_cfg_shifter.sv
module ps_cfg_shifter
    import ps_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  byte_beat_t beat,
    input  logic       advance,
    output logic       bit_o,
    output logic       last_bit,
    output logic       last_byte
);
    logic [7:0] sreg;
    logic [2:0] bcnt;
    logic       lastq;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg  <= '0;
            bcnt  <= '0;
            lastq <= 1'b0;
        end else if (load) begin
            sreg  <= beat.data;
            bcnt  <= '0;
            lastq <= beat.last;
        end else if (advance) begin
            sreg  <= {1'b0, sreg[7:1]};
            bcnt  <= bcnt + 1'b1;
        end
    end

    assign bit_o     = sreg[0];
    assign last_bit  = (bcnt == 3'd7);
    assign last_byte = lastq;

    // R5
    lsb_first_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (bit_o == $past(beat.data[0])) && !last_bit);

endmodule

// File: rtl/ps_config_master.sv
module ps_config_master
    import ps_cfg_pkg::*;
#(
    parameter longint unsigned CLK_HZ       = 64'd125_000_000,
    parameter int unsigned     T_CFG_CYC    = 313,
    parameter int unsigned     T_REL_CYC    = 250,
    parameter int unsigned     T_TMO_CYC    = 12_500_000,
    parameter int unsigned     HALF_CYC     = 2,
    parameter int unsigned     TRAIL_PULSES = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] s_data,
    input  logic       s_valid,
    input  logic       s_last,
    output logic       s_ready,
    output logic       ncfg_o,
    output logic       dclk_o,
    output logic       data0_o,
    input  logic       nstatus_i,
    input  logic       confdone_i,
    output logic       busy,
    output logic       done,
    output logic       error,
    output logic [1:0] err_code
);
    localparam int unsigned CNT_W = $clog2(max4(T_CFG_CYC, T_REL_CYC, T_TMO_CYC, HALF_CYC) + 1);
    localparam int unsigned PC_W  = (TRAIL_PULSES > 1) ? $clog2(TRAIL_PULSES) : 1;
    localparam logic [CNT_W-1:0] V_CFG  = CNT_W'(T_CFG_CYC - 1);
    localparam logic [CNT_W-1:0] V_REL  = CNT_W'(T_REL_CYC - 1);
    localparam logic [CNT_W-1:0] V_TMO  = CNT_W'(T_TMO_CYC - 1);
    localparam logic [CNT_W-1:0] V_HALF = CNT_W'(HALF_CYC - 1);
    localparam logic [PC_W-1:0]  PC_END = PC_W'(TRAIL_PULSES - 1);

    // R6
    initial begin
        rate_ok_chk: assert (dclk_rate_ok(CLK_HZ, HALF_CYC))
            else $error("serial clock half period too short for 50 MHz limit");
    end

    seq_state_e        state, st_n;
    logic              phase, ph_n;
    logic [PC_W-1:0]   pcnt, pc_n;
    logic              err_q, err_n, done_q, done_n;
    err_e              code_q, code_n;

    logic              tload, tzero;
    logic [CNT_W-1:0]  tval;
    logic              sh_load, sh_adv, sh_bit, sh_last_bit, sh_last_byte;
    byte_beat_t        beat;

    assign beat = '{data: s_data, last: s_last};

    ps_cfg_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tload),
        .load_val (tval),
        .zero     (tzero)
    );

    ps_cfg_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (sh_load),
        .beat      (beat),
        .advance   (sh_adv),
        .bit_o     (sh_bit),
        .last_bit  (sh_last_bit),
        .last_byte (sh_last_byte)
    );

    always_comb begin
        st_n    = state;
        ph_n    = phase;
        pc_n    = pcnt;
        err_n   = err_q;
        code_n  = code_q;
        done_n  = done_q;
        tload   = 1'b0;
        tval    = '0;
        sh_load = 1'b0;
        sh_adv  = 1'b0;
        unique case (state)
            S_IDLE: if (start) begin
                st_n   = S_CFG;
                err_n  = 1'b0;
                code_n = ERR_NONE;
                done_n = 1'b0;
                tload  = 1'b1;
                tval   = V_CFG;
            end
            S_CFG: if (tzero) begin
                if (nstatus_i) begin
                    st_n   = S_IDLE;
                    err_n  = 1'b1;
                    code_n = ERR_NOSTAT;
                end else begin
                    st_n  = S_REL;
                    tload = 1'b1;
                    tval  = V_REL;
                end
            end
            S_REL: if (tzero) begin
                st_n  = S_WAIT;
                tload = 1'b1;
                tval  = V_TMO;
            end
            S_WAIT: begin
                if (nstatus_i) begin
                    st_n = S_LOAD;
                end else if (tzero) begin
                    st_n   = S_IDLE;
                    err_n  = 1'b1;
                    code_n = ERR_TMO;
                end
            end
            S_LOAD: if (s_valid) begin
                sh_load = 1'b1;
                st_n    = S_SHIFT;
                ph_n    = 1'b0;
                tload   = 1'b1;
                tval    = V_HALF;
            end
            S_SHIFT: if (tzero) begin
                if (!phase) begin
                    ph_n  = 1'b1;
                    tload = 1'b1;
                    tval  = V_HALF;
                end else begin
                    ph_n = 1'b0;
                    if (sh_last_bit) begin
                        st_n = sh_last_byte ? S_CHK : S_LOAD;
                    end else begin
                        sh_adv = 1'b1;
                        tload  = 1'b1;
                        tval   = V_HALF;
                    end
                end
            end
            S_CHK: begin
                if (confdone_i) begin
                    st_n  = S_TRAIL;
                    ph_n  = 1'b1;
                    pc_n  = '0;
                    tload = 1'b1;
                    tval  = V_HALF;
                end else begin
                    st_n   = S_IDLE;
                    err_n  = 1'b1;
                    code_n = ERR_CONF;
                end
            end
            S_TRAIL: if (tzero) begin
                tload = 1'b1;
                tval  = V_HALF;
                if (phase) begin
                    ph_n = 1'b0;
                end else if (pcnt == PC_END) begin
                    st_n   = S_IDLE;
                    done_n = 1'b1;
                    tload  = 1'b0;
                end else begin
                    ph_n = 1'b1;
                    pc_n = pcnt + 1'b1;
                end
            end
            default: st_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            phase  <= 1'b0;
            pcnt   <= '0;
            err_q  <= 1'b0;
            code_q <= ERR_NONE;
            done_q <= 1'b0;
        end else begin
            state  <= st_n;
            phase  <= ph_n;
            pcnt   <= pc_n;
            err_q  <= err_n;
            code_q <= code_n;
            done_q <= done_n;
        end
    end

    assign ncfg_o   = (state != S_CFG);
    assign dclk_o   = ((state == S_SHIFT) || (state == S_TRAIL)) && phase;
    assign data0_o  = (state == S_SHIFT) && sh_bit;
    assign s_ready  = (state == S_LOAD);
    assign busy     = (state != S_IDLE);
    assign done     = done_q;
    assign error    = err_q;
    assign err_code = code_q;

    // R10
    err_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(error) |-> (ncfg_o && !dclk_o && !busy));

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        dclk_o |-> $stable(data0_o));

    // R7
    take_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_ready) |=> (!dclk_o && !s_ready));

    // R6
    half_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dclk_o) |-> $past(tzero));

    // R9
    done_clean_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (!error && !busy && ncfg_o));

    // R3
    code_set_chk: assert property (@(posedge clk) disable iff (rst)
        error |-> (err_code != 2'd0));

endmodule

// File: tb/ps_config_master_tb.sv
module ps_config_master_tb;
    localparam int CFG = 5, REL = 4, TMO = 60, HALF = 2, TRAIL = 12, RELDLY = 7;
    localparam int M_OK = 0, M_STUCK = 1, M_NOREL = 2, M_CDLOW = 3;

    // fields: mode[21:20] nbytes[19:14] seed[13:6] gap[5:2] exp_err[1:0]
    localparam logic [21:0] VEC [7] = '{
        {2'd0, 6'd3, 8'hA5, 4'd0, 2'd0},
        {2'd0, 6'd1, 8'h01, 4'd3, 2'd0},
        {2'd1, 6'd2, 8'h3C, 4'd0, 2'd1},
        {2'd0, 6'd4, 8'h80, 4'd5, 2'd0},
        {2'd2, 6'd2, 8'h11, 4'd0, 2'd2},
        {2'd3, 6'd2, 8'h5A, 4'd1, 2'd3},
        {2'd0, 6'd2, 8'hFF, 4'd1, 2'd0}
    };

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, start, s_valid, s_last, s_ready;
    logic [7:0] s_data;
    logic ncfg_o, dclk_o, data0_o, busy, done, error;
    logic [1:0] err_code;
    logic nstat = 1'b1, cdone = 1'b0;

    ps_config_master #(
        .CLK_HZ(64'd125_000_000), .T_CFG_CYC(CFG), .T_REL_CYC(REL),
        .T_TMO_CYC(TMO), .HALF_CYC(HALF), .TRAIL_PULSES(TRAIL)
    ) u_dut (
        .clk(clk), .rst(rst), .start(start), .s_data(s_data), .s_valid(s_valid),
        .s_last(s_last), .s_ready(s_ready), .ncfg_o(ncfg_o), .dclk_o(dclk_o),
        .data0_o(data0_o), .nstatus_i(nstat), .confdone_i(cdone), .busy(busy),
        .done(done), .error(error), .err_code(err_code)
    );

    int nchk = 0, nfail = 0;
    int mode = M_OK, nb_m = 0, gap_m = 0;
    logic [7:0] seed_m = 8'h00;
    int relc = 0, bits = 0, bytes_ok = 0, bytes_bad = 0, trail = 0;
    int ncfg_w = 0, hcnt = 0, hbad = 0, stall_bad = 0;
    logic [7:0] cap = 8'h00;
    logic feed_rst = 1'b1;
    int idx = 0, gapc = 0;

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
        return seed + 8'(i * 37);
    endfunction

    // device status model
    always @(posedge clk) begin
        if (mode == M_STUCK) nstat <= 1'b1;
        else if (!ncfg_o) begin nstat <= 1'b0; relc <= 0; end
        else if (!nstat && mode != M_NOREL) begin
            relc <= relc + 1;
            if (relc == RELDLY) nstat <= 1'b1;
        end
    end

    // device data capture on rising serial clock
    always @(posedge dclk_o) begin
        if (!cdone) begin
            cap = {data0_o, cap[7:1]};
            bits++;
            if (bits % 8 == 0) begin
                if (cap == pat(seed_m, bits / 8 - 1)) bytes_ok++;
                else bytes_bad++;
                if (bits == nb_m * 8 && mode != M_CDLOW) cdone = 1'b1;
            end
        end else trail++;
    end

    // link monitor
    always @(posedge clk) begin
        if (!ncfg_o) ncfg_w++;
        if (dclk_o) hcnt++;
        else if (hcnt != 0) begin
            if (hcnt != HALF) hbad++;
            hcnt = 0;
        end
        if (s_ready && dclk_o) stall_bad++;
    end

    // byte stream source
    always @(posedge clk) begin
        if (feed_rst) begin
            idx <= 0; gapc <= 0; s_valid <= 1'b0; s_data <= 8'h00; s_last <= 1'b0;
        end else if (s_valid && s_ready) begin
            s_valid <= 1'b0; idx <= idx + 1; gapc <= gap_m;
        end else if (!s_valid && idx < nb_m) begin
            if (gapc == 0) begin
                s_valid <= 1'b1; s_data <= pat(seed_m, idx); s_last <= (idx == nb_m - 1);
            end else gapc <= gapc - 1;
        end
    end

    initial begin
        #(8 * 200000);
        nfail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 ncfg", ncfg_o, 1);  check("R1 dclk", dclk_o, 0);
        check("R1 data0", data0_o, 0); check("R1 busy", busy, 0);
        check("R1 done", done, 0);    check("R1 error", error, 0);
        check("R1 ready", s_ready, 0);
        rst = 1'b0;
        // R11 bytes offered while idle are not taken
        nb_m = 2; seed_m = 8'h42; gap_m = 0; feed_rst = 1'b0;
        repeat (10) @(negedge clk);
        check("R11 idle ready", s_ready, 0);
        check("R11 idle valid held", s_valid, 1);
        check("R11 idle edges", bits, 0);

        for (int v = 0; v < 7; v++) begin
            int exp_err, w, exp_bytes;
            mode = VEC[v][21:20]; exp_err = VEC[v][1:0];
            @(negedge clk);
            feed_rst = 1'b1;
            nb_m = VEC[v][19:14]; seed_m = VEC[v][13:6]; gap_m = VEC[v][5:2];
            bits = 0; bytes_ok = 0; bytes_bad = 0; trail = 0; cdone = 1'b0;
            ncfg_w = 0; hbad = 0; stall_bad = 0; hcnt = 0;
            @(negedge clk);
            feed_rst = 1'b0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            // R2 / R11 start clears previous result
            check("R2 busy after start", busy, 1);
            check("R2 error cleared", error, 0);
            check("R2 done cleared", done, 0);
            w = 0;
            while (busy && w < 20000) begin @(negedge clk); w++; end
            check("watchdog per vector", (w >= 20000), 0);
            exp_bytes = (exp_err == 0 || exp_err == 3) ? nb_m : 0;
            check("R2 ncfg low width", ncfg_w, CFG);
            check("R10 err code", err_code, exp_err);
            check("R10 error flag", error, (exp_err != 0));
            check("R9 done flag", done, (exp_err == 0));
            check("R5 bytes matched", bytes_ok, exp_bytes);
            check("R5 bytes mismatched", bytes_bad, 0);
            check("R9/R8 trailing pulses", trail, (exp_err == 0) ? TRAIL : 0);
            check("R6 high phase length", hbad, 0);
            check("R7 clock during stall", stall_bad, 0);
            check("R10 ncfg idle", ncfg_o, 1);
            check("R10 dclk idle", dclk_o, 0);
            if (exp_err == 1) check("R3 busy length", w, CFG);
            if (exp_err == 2) check("R4 timeout length", w, CFG + REL + TMO);
            if (exp_err == 1 || exp_err == 2) check("R11 early edges", bits, 0);
            repeat (6) @(negedge clk);
            check("R10 code held", err_code, exp_err);
            check("R11 no take when idle", s_ready, 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule